// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit device address into a physical address. It walks a translation table in memory that has two levels. A request is accepted only while the walker is idle. The walker then reads one first-level descriptor through a 32-bit read port. If that descriptor points to a second-level table, it reads one more descriptor. It then reports either a translation or a fault, and holds that result until the requester acknowledges it.

Four mapping sizes share the same table format: 4 KB, 64 KB, 1 MB and 16 MB. A 16 MB mapping fills 16 neighbouring first-level slots with the same descriptor. A 64 KB mapping does the same with 16 neighbouring second-level slots. The walker therefore needs no special indexing for them. It reads the slot that the address selects and merges the address bits. The result is the descriptor bits above the page boundary, combined with the device address bits below it. When a walk ends in a mapping, the walker also gives a translation look-aside buffer one fill entry: the page-aligned device base, the page-aligned physical base and the size code.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, while `rsp_valid`, `mem_req` and `tlb_fill_valid` are all 0.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. In the next cycle `mem_req` is 1 and `mem_addr` = {`ttb_base`[31:14], address[31:20], 2'b00}. Base bits 13:0 are ignored. `req_ready` stays low until the result is acknowledged, so `req_valid` is ignored while a walk is busy.
- R3: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr` does not change. `mem_rdata` is taken in the cycle where `mem_rvalid` is high. `mem_req` and `rsp_valid` are never high together.
- R4: A first-level descriptor with bits 1:0 = 2'b10 and bit 18 = 0 maps 1 MB. The physical address is {desc[31:20], address[19:0]} and `rsp_size` = 2. The result becomes valid in the cycle after the read response.
- R5: A first-level descriptor with bits 1:0 = 2'b10 and bit 18 = 1 maps 16 MB. The physical address is {desc[31:24], address[23:0]} and `rsp_size` = 3. Any of the 16 replicated slots therefore gives the same translation.
- R6: A first-level descriptor with bits 1:0 = 2'b01 points to a table. In the next cycle a second read is issued at {desc[31:10], address[19:12], 2'b00}.
- R7: A second-level descriptor with bits 1:0 = 2'b01 maps 64 KB. The physical address is {desc[31:16], address[15:0]} and `rsp_size` = 1.
- R8: A second-level descriptor with bit 1 set (bits 1:0 = 2'b10 or 2'b11) maps 4 KB. The physical address is {desc[31:12], address[11:0]} and `rsp_size` = 0.
- R9: A fault is reported in three cases: a first-level type of 2'b00 (which includes an all-zero descriptor), a first-level type of 2'b11, and a second-level type of 2'b00. On a fault `rsp_valid` and `rsp_fault` are 1, `rsp_fault_addr` is the device address, `rsp_pa` is 0, and no further read is made.
- R10: While `rsp_valid` is high and `rsp_ack` is low, `rsp_pa`, `rsp_size` and `rsp_fault` hold their values. After `rsp_ack`, the walker is idle in the next cycle.
- R11: `tlb_fill_valid` is a one-cycle pulse in the first cycle of a successful result and never appears on a fault. It carries `tlb_fill_va` = address AND page mask, `tlb_fill_pa` = physical address AND page mask, and `tlb_fill_size` = the size code.
- R12: The whole 32-bit range can be translated, including address 0 (first-level index 0) and address 0xFFFFFFFF (first-level index 4095).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ttb_base | input | 32 | First-level table base, 16 KB aligned |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Device address to translate |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req | output | 1 | Descriptor read request, held until response |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Descriptor read data |
| rsp_valid | output | 1 | Result available |
| rsp_fault | output | 1 | Result is a translation fault |
| rsp_pa | output | 32 | Translated physical address |
| rsp_size | output | 2 | Page size code: 0=4K, 1=64K, 2=1M, 3=16M |
| rsp_fault_addr | output | 32 | Device address that faulted |
| rsp_ack | input | 1 | Requester takes the result |
| tlb_fill_valid | output | 1 | One-cycle fill strobe |
| tlb_fill_va | output | 32 | Page-aligned device base |
| tlb_fill_pa | output | 32 | Page-aligned physical base |
| tlb_fill_size | output | 2 | Page size code of the fill |

## Verification
Each result has a fixed point in time:
- The first-level read address is due one cycle after a request is accepted.
- A second-level read address is due one cycle after the first read response.
- `rsp_valid`, the translation or fault fields, and the fill pulse are due one cycle after the last read response.
- Idle is due one cycle after `rsp_ack`.

The bench drives every input at the falling edge and samples at the next falling edge. It checks the read address on every cycle of a read, using response latencies of one to four cycles. It compares each result with a behavioural walk of its own memory image at exactly the cycle given above. While the acknowledge is withheld, it checks on every cycle that the result holds.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W     = 32;
    localparam int L1_IDX_LSB = 20;
    localparam int L1_IDX_W   = ADDR_W - L1_IDX_LSB;
    localparam int L2_IDX_LSB = 12;
    localparam int L2_IDX_W   = L1_IDX_LSB - L2_IDX_LSB;
    localparam int WORD_LSB   = 2;
    localparam int TTB_ALIGN  = L1_IDX_W + WORD_LSB;
    localparam int L2T_ALIGN  = L2_IDX_W + WORD_LSB;
    localparam int SUPER_BIT  = 18;

    localparam logic [ADDR_W-1:0] TTB_MASK = {ADDR_W{1'b1}} << TTB_ALIGN;
    localparam logic [ADDR_W-1:0] L2T_MASK = {ADDR_W{1'b1}} << L2T_ALIGN;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_64K = 2'd1,
        SZ_1M  = 2'd2,
        SZ_16M = 2'd3
    } pgsz_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1,
        ST_L2,
        ST_DONE,
        ST_FAULT
    } wstate_e;

    typedef struct packed {
        logic  fault;
        logic  next_level;
        pgsz_e size;
    } dinfo_t;

    function automatic logic [ADDR_W-1:0] page_mask(input pgsz_e sz);
        logic [ADDR_W-1:0] m;
        case (sz)
            SZ_4K:   m = {ADDR_W{1'b1}} << 12;
            SZ_64K:  m = {ADDR_W{1'b1}} << 16;
            SZ_1M:   m = {ADDR_W{1'b1}} << 20;
            default: m = {ADDR_W{1'b1}} << 24;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xlat_desc_decode.sv
module xlat_desc_decode
    import xlat_pkg::*;
(
    input  logic [1:0] desc_type,
    input  logic       ext_bit,
    input  logic       second_level,
    output dinfo_t     info
);

    always_comb begin
        info.fault      = 1'b1;
        info.next_level = 1'b0;
        info.size       = SZ_4K;
        if (!second_level) begin
            case (desc_type)
                2'b01: begin
                    info.fault      = 1'b0;
                    info.next_level = 1'b1;
                end
                2'b10: begin
                    info.fault = 1'b0;
                    info.size  = ext_bit ? SZ_16M : SZ_1M;
                end
                default: ;
            endcase
        end else begin
            case (desc_type)
                2'b01: begin
                    info.fault = 1'b0;
                    info.size  = SZ_64K;
                end
                2'b10, 2'b11: begin
                    info.fault = 1'b0;
                    info.size  = SZ_4K;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xlat_addr_merge.sv
module xlat_addr_merge
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    input  pgsz_e             size,
    output logic [ADDR_W-1:0] pa
);

    logic [ADDR_W-1:0] keep;

    always_comb begin
        keep = page_mask(size);
        pa   = (desc & keep) | (va & ~keep);
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ttb_base,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        req_ready,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_pa,
    output logic [1:0]  rsp_size,
    output logic [31:0] rsp_fault_addr,
    input  logic        rsp_ack,
    output logic        tlb_fill_valid,
    output logic [31:0] tlb_fill_va,
    output logic [31:0] tlb_fill_pa,
    output logic [1:0]  tlb_fill_size
);

    wstate_e           st_q, st_d;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] l1_q;
    logic [ADDR_W-1:0] res_pa_q;
    pgsz_e             res_sz_q;
    logic              fill_q;

    dinfo_t            info;
    logic [ADDR_W-1:0] merged;
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;
    logic [ADDR_W-1:0] res_mask;
    logic              fetching;
    logic              leaf_rsp;

    xlat_desc_decode u_decode (
        .desc_type    (mem_rdata[1:0]),
        .ext_bit      (mem_rdata[SUPER_BIT]),
        .second_level (st_q == ST_L2),
        .info         (info)
    );

    xlat_addr_merge u_merge (
        .desc (mem_rdata),
        .va   (va_q),
        .size (info.size),
        .pa   (merged)
    );

    // descriptor addresses for both levels
    always_comb begin
        l1_addr = (ttb_base & TTB_MASK)
                | {{(ADDR_W-TTB_ALIGN){1'b0}}, va_q[ADDR_W-1:L1_IDX_LSB], 2'b00};
        l2_addr = (l1_q & L2T_MASK)
                | {{(ADDR_W-L2T_ALIGN){1'b0}}, va_q[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
    end

    assign fetching = (st_q == ST_L1) || (st_q == ST_L2);
    assign leaf_rsp = fetching && mem_rvalid && !info.next_level;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (req_valid) st_d = ST_L1;
            ST_L1:    if (mem_rvalid) begin
                          if (info.fault)           st_d = ST_FAULT;
                          else if (info.next_level) st_d = ST_L2;
                          else                      st_d = ST_DONE;
                      end
            ST_L2:    if (mem_rvalid) st_d = info.fault ? ST_FAULT : ST_DONE;
            ST_DONE,
            ST_FAULT: if (rsp_ack) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            va_q     <= '0;
            l1_q     <= '0;
            res_pa_q <= '0;
            res_sz_q <= SZ_4K;
            fill_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            fill_q <= (st_d == ST_DONE) && (st_q != ST_DONE);
            if (st_q == ST_IDLE && req_valid)
                va_q <= req_addr;
            if (st_q == ST_L1 && mem_rvalid)
                l1_q <= mem_rdata;
            if (leaf_rsp) begin
                res_pa_q <= info.fault ? '0 : merged;
                res_sz_q <= info.fault ? SZ_4K : info.size;
            end
        end
    end

    always_comb begin
        req_ready      = (st_q == ST_IDLE);
        mem_req        = fetching;
        case (st_q)
            ST_L1:   mem_addr = l1_addr;
            ST_L2:   mem_addr = l2_addr;
            default: mem_addr = '0;
        endcase
        rsp_valid      = (st_q == ST_DONE) || (st_q == ST_FAULT);
        rsp_fault      = (st_q == ST_FAULT);
        rsp_pa         = res_pa_q;
        rsp_size       = res_sz_q;
        rsp_fault_addr = (st_q == ST_FAULT) ? va_q : '0;
        res_mask       = page_mask(res_sz_q);
        tlb_fill_valid = fill_q;
        tlb_fill_va    = va_q & res_mask;
        tlb_fill_pa    = res_pa_q & res_mask;
        tlb_fill_size  = res_sz_q;
    end

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] ttb_base,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        rsp_valid,
    input logic        rsp_ack,
    input logic        rsp_fault,
    input logic [31:0] rsp_pa,
    input logic [1:0]  rsp_size,
    input logic        tlb_fill_valid
);

    p_l1_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> mem_req
            && ((mem_addr & 32'hFFFF_C000) == (ttb_base & 32'hFFFF_C000))
            && (mem_addr[13:2] == 12'($past(req_addr) >> 20)))
        else $error("p_l1_addr_r2");

    p_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req || rsp_valid) |-> !req_ready)
        else $error("p_busy_r2");

    p_hold_read_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr))
        else $error("p_hold_read_r3");

    p_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && rsp_valid))
        else $error("p_excl_r3");

    p_fault_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == 32'd0))
        else $error("p_fault_zero_r9");

    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ack) |=> rsp_valid && $stable(rsp_pa)
            && $stable(rsp_fault) && $stable(rsp_size))
        else $error("p_result_hold_r10");

    p_ack_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ack) |=> req_ready && !rsp_valid)
        else $error("p_ack_idle_r10");

    p_fill_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        tlb_fill_valid |=> !tlb_fill_valid)
        else $error("p_fill_pulse_r11");

    p_fill_ok_r11: assert property (@(posedge clk) disable iff (rst)
        tlb_fill_valid |-> (rsp_valid && !rsp_fault))
        else $error("p_fill_ok_r11");

endmodule

bind xlat_walker xlat_walker_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .ttb_base       (ttb_base),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_ready      (req_ready),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_rvalid     (mem_rvalid),
    .rsp_valid      (rsp_valid),
    .rsp_ack        (rsp_ack),
    .rsp_fault      (rsp_fault),
    .rsp_pa         (rsp_pa),
    .rsp_size       (rsp_size),
    .tlb_fill_valid (tlb_fill_valid)
);

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;

    localparam logic [31:0] TTB  = 32'h0010_2A5C;
    localparam logic [31:0] L1B  = TTB & 32'hFFFF_C000;
    localparam logic [31:0] L2T  = 32'h0008_07F1;
    localparam logic [31:0] L2B  = L2T & 32'hFFFF_FC00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_size;
    logic [31:0] rsp_fault_addr;
    logic        rsp_ack = 1'b0;
    logic        tlb_fill_valid;
    logic [31:0] tlb_fill_va;
    logic [31:0] tlb_fill_pa;
    logic [1:0]  tlb_fill_size;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  done    = 1'b0;
    logic [31:0] tbl [logic [31:0]];

    always #2.5 clk = ~clk;

    xlat_walker i_xlat_walker (
        .clk(clk), .rst(rst), .ttb_base(TTB),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_size(rsp_size), .rsp_fault_addr(rsp_fault_addr), .rsp_ack(rsp_ack),
        .tlb_fill_valid(tlb_fill_valid), .tlb_fill_va(tlb_fill_va),
        .tlb_fill_pa(tlb_fill_pa), .tlb_fill_size(tlb_fill_size)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return tbl.exists(a) ? tbl[a] : 32'd0;
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        int sh = 12 + 4 * int'(sz);
        return 32'hFFFF_FFFF << sh;
    endfunction

    // behavioural walk of the bench memory image
    task automatic ref_walk(input logic [31:0] va,
                            output logic [31:0] a1, output logic [31:0] a2,
                            output int nacc, output bit flt,
                            output logic [31:0] pa, output logic [1:0] sz);
        logic [31:0] d1, d2;
        a1 = L1B + (va >> 20) * 4;
        d1 = rd(a1);
        nacc = 1; a2 = '0; flt = 1'b0; pa = '0; sz = 2'd0;
        if (d1[1:0] == 2'b10) begin
            sz = d1[18] ? 2'd3 : 2'd2;
            pa = (d1 & size_mask(sz)) | (va & ~size_mask(sz));
        end else if (d1[1:0] == 2'b01) begin
            a2 = (d1 & 32'hFFFF_FC00) + ((va >> 12) & 32'hFF) * 4;
            d2 = rd(a2);
            nacc = 2;
            if (d2[1]) sz = 2'd0;
            else if (d2[0]) sz = 2'd1;
            else flt = 1'b1;
            if (!flt) pa = (d2 & size_mask(sz)) | (va & ~size_mask(sz));
        end else begin
            flt = 1'b1;
        end
    endtask

    task automatic do_walk(input logic [31:0] va, input int lat,
                           input int hold, input bit noise, input string tag);
        logic [31:0] a1, a2, epa, exp_a;
        int nacc;
        bit flt;
        logic [1:0] esz;
        ref_walk(va, a1, a2, nacc, flt, epa, esz);
        @(negedge clk);
        req_addr  = va;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, {"R2 ready when idle ", tag}, {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = noise;
        req_addr  = ~va;
        for (int acc = 0; acc < nacc; acc++) begin
            exp_a = (acc == 0) ? a1 : a2;
            for (int c = 0; c < lat; c++) begin
                chk(mem_req == 1'b1, {"R3 read held ", tag}, {31'd0, mem_req}, 32'd1);
                chk(mem_addr == exp_a, acc == 0 ? {"R2 L1 address ", tag} : {"R6 L2 address ", tag},
                    mem_addr, exp_a);
                chk(req_ready == 1'b0, {"R2 busy ignores request ", tag}, {31'd0, req_ready}, 32'd0);
                if (c == lat - 1) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd(exp_a);
                end
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = 32'hDEAD_BEEF;
            end
        end
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {"R4 result due ", tag}, {31'd0, rsp_valid}, 32'd1);
        chk(mem_req == 1'b0, {"R9 no extra read ", tag}, {31'd0, mem_req}, 32'd0);
        chk(rsp_fault == flt, {"R9 fault flag ", tag}, {31'd0, rsp_fault}, {31'd0, flt});
        chk(rsp_pa == epa, {"R4 R5 R7 R8 address ", tag}, rsp_pa, epa);
        if (flt) begin
            chk(rsp_fault_addr == va, {"R9 fault address ", tag}, rsp_fault_addr, va);
            chk(tlb_fill_valid == 1'b0, {"R11 no fill on fault ", tag}, {31'd0, tlb_fill_valid}, 32'd0);
        end else begin
            chk(rsp_size == esz, {"R5 R7 R8 size ", tag}, {30'd0, rsp_size}, {30'd0, esz});
            chk(tlb_fill_valid == 1'b1, {"R11 fill pulse ", tag}, {31'd0, tlb_fill_valid}, 32'd1);
            chk(tlb_fill_va == (va & size_mask(esz)), {"R11 fill va ", tag},
                tlb_fill_va, va & size_mask(esz));
            chk(tlb_fill_pa == (epa & size_mask(esz)), {"R11 fill pa ", tag},
                tlb_fill_pa, epa & size_mask(esz));
            chk(tlb_fill_size == esz, {"R11 fill size ", tag}, {30'd0, tlb_fill_size}, {30'd0, esz});
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b1 && rsp_pa == epa && rsp_fault == flt,
                {"R10 result held ", tag}, rsp_pa, epa);
            chk(tlb_fill_valid == 1'b0, {"R11 single pulse ", tag}, {31'd0, tlb_fill_valid}, 32'd0);
        end
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, {"R10 idle after ack ", tag},
            {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    initial begin
        // first-level image
        tbl[L1B + 32'h123 * 4] = 32'h9AB0_0C02;
        for (int i = 0; i < 16; i++) tbl[L1B + (32'h340 + i) * 4] = 32'hC504_0002;
        tbl[L1B + 32'h400 * 4] = L2T;
        tbl[L1B + 32'h556 * 4] = 32'hDEAD_0003;
        tbl[L1B + 32'hFFF * 4] = 32'h0120_0002;
        tbl[L1B]               = 32'hFFF0_0002;
        // second-level image
        tbl[L2B + 32'h56 * 4]  = 32'hABCD_E002;
        tbl[L2B + 32'h57 * 4]  = 32'h1357_9FF3;
        for (int i = 0; i < 16; i++) tbl[L2B + (32'h60 + i) * 4] = 32'h7777_0001;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0 && tlb_fill_valid == 1'b0,
            "R1 reset state", {28'd0, req_ready, rsp_valid, mem_req, tlb_fill_valid}, 32'h8);

        do_walk(32'h1234_5678, 1, 0, 1'b0, "R4 section");
        do_walk(32'h34A0_1234, 2, 2, 1'b0, "R5 super");
        do_walk(32'h34F9_9999, 3, 0, 1'b1, "R5 super other slot");
        do_walk(32'h4005_6ABC, 1, 1, 1'b0, "R8 small 10");
        do_walk(32'h4005_7123, 4, 0, 1'b0, "R8 small 11");
        do_walk(32'h4006_5432, 2, 3, 1'b1, "R7 large");
        do_walk(32'h4006_F00D, 1, 0, 1'b0, "R7 large last slot");
        do_walk(32'h5550_0000, 2, 1, 1'b0, "R9 L1 zero");
        do_walk(32'h5561_0000, 1, 0, 1'b0, "R9 L1 type 11");
        do_walk(32'h4009_9000, 3, 2, 1'b0, "R9 L2 zero");
        do_walk(32'hFFFF_FFFF, 1, 0, 1'b0, "R12 top");
        do_walk(32'h0000_0000, 2, 0, 1'b0, "R12 bottom");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule